// File: doc/BRIEF.md
# Significance-Flag Binary32 Converter

This block translates between ordinary binary32 words and a binary32 variant that records, inside the mantissa itself, how many mantissa bits can be trusted. The marker is the lowest set bit of the 23-bit mantissa. Bits above that marker are significant. The marker and every bit below it carry no information. Because the count lives in the word, no extra field is stored or moved.

Three conversions are chosen by a mode input:

- **Encode** takes a plain word and a requested precision. It cuts the mantissa down to that many leading bits and places the marker directly below them.
- **Decode** finds the marker, clears it, and reports how many significant bits the word held.
- **Mark full precision** turns a plain word into a flagged word that claims all available precision.

Zero, infinities and NaN take no marker and leave the block unchanged. A flagged word whose mantissa is all zeros carries no significant bits. It stands only for the size of an error, and the block reports it through an error output. All outputs are registered and appear one clock after the inputs.

Top module: `anr_convert`

## Requirements
- R1: While rstN is low and after it is released until the first applied input, outWord, outPrec, isSpecial and isErr are all zero.
- R2: A special input (exponent 8'hFF, or exponent 0 with mantissa 0) appears unchanged on outWord in every mode, with isSpecial=1, isErr=0 and outPrec=0.
- R3: In encode mode (mode=2'd0) with a signed 6-bit precReq p between 1 and 22, the top p mantissa bits [22:23-p] are kept. Mantissa bit 22-p is set and all lower bits are cleared. outPrec is p.
- R4: In encode mode a precReq above 22 behaves exactly as a precReq of 22: bit 0 is set and outPrec is 22.
- R5: In encode mode a precReq of zero or below yields the error encoding. Sign and exponent are kept, the mantissa is zero, outPrec is 0 and isErr is 1.
- R6: In decode mode (mode=2'd1), for a non-special input whose lowest set mantissa bit is at position c, outWord equals the input with bit c cleared, and outPrec is 22-c.
- R7: In decode mode a non-special input with an all-zero mantissa yields the error encoding with isErr=1, as in R5.
- R8: In mark mode (mode=2'd2) a non-special input leaves with mantissa bit 0 forced to 1, all other bits unchanged, and outPrec=22.
- R9: Mode 2'd3 behaves exactly as decode mode.
- R10: outWord[31:23] (sign and exponent) always equals the input sign and exponent of the previous cycle.
- R11: Every output reflects the inputs sampled at the preceding rising clock edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 encode, 1 decode, 2 mark full precision, 3 decode |
| precReq | input | 6 | Signed requested precision for encode |
| inSign | input | 1 | Input sign bit |
| inExp | input | 8 | Input biased exponent |
| inMant | input | 23 | Input mantissa |
| outWord | output | 32 | Converted word {sign, exponent, mantissa} |
| outPrec | output | 5 | Significant-bit count (0 to 22) |
| isSpecial | output | 1 | Input was zero, infinity or NaN |
| isErr | output | 1 | Result is the error encoding |

## Verification
The only state in the block is the output register. A fault in the prefix-OR significance chain shows on the very next cycle as a marker at the wrong position, or as an outPrec that is off by the distance to the true lowest set bit. Faults in the classification strobes show as a special value that is rewritten, or as an error flag raised on a good word. The sweeps place the marker at every position from 0 to 22 and push precReq past both clamp boundaries, so each such fault reaches the ports one clock after the offending input.

// File: rtl/anr_pkg.sv
package anr_pkg;

  parameter int EXP_W  = 8;
  parameter int MANT_W = 23;
  parameter int PREQ_W = 6;
  parameter int PREC_W = 5;

  localparam int MAX_PREC = MANT_W - 1;
  localparam int WORD_W   = 1 + EXP_W + MANT_W;

  typedef enum logic [1:0] {
    MODE_ENCODE  = 2'd0,
    MODE_DECODE  = 2'd1,
    MODE_TOFLAG  = 2'd2,
    MODE_DECODE2 = 2'd3
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              special;
    logic              err;
    logic              doEncode;
    logic              doFlag;
    logic              doDecode;
    logic [PREC_W-1:0] encPrec;
  } strobe_t;

endpackage

// File: rtl/anr_ctrl.sv
module anr_ctrl
  import anr_pkg::*;
(
  input  logic [1:0]               mode,
  input  logic signed [PREQ_W-1:0] precReq,
  input  logic [EXP_W-1:0]         inExp,
  input  logic                     mantZero,
  output strobe_t                  strobes
);

  int   reqVal;
  logic expOnes;
  logic expZero;
  logic special;
  logic encSel;
  logic flagSel;
  logic decSel;

  assign reqVal  = int'(precReq);
  assign expOnes = &inExp;
  assign expZero = (inExp == '0);
  assign special = expOnes | (expZero & mantZero);

  always_comb begin
    encSel  = 1'b0;
    flagSel = 1'b0;
    decSel  = 1'b0;
    unique case (mode_e'(mode))
      MODE_ENCODE:  encSel  = 1'b1;
      MODE_TOFLAG:  flagSel = 1'b1;
      MODE_DECODE,
      MODE_DECODE2: decSel  = 1'b1;
      default:      decSel  = 1'b1;
    endcase
  end

  always_comb begin
    strobes          = '0;
    strobes.special  = special;
    strobes.doEncode = encSel  & ~special;
    strobes.doFlag   = flagSel & ~special;
    strobes.doDecode = decSel  & ~special;
    strobes.err      = ~special & ((encSel & (reqVal <= 0)) | (decSel & mantZero));
    if (reqVal <= 0)
      strobes.encPrec = '0;
    else if (reqVal > MAX_PREC)
      strobes.encPrec = PREC_W'(MAX_PREC);
    else
      strobes.encPrec = PREC_W'(reqVal);
  end

endmodule

// File: rtl/anr_datapath.sv
module anr_datapath
  import anr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              inSign,
  input  logic [EXP_W-1:0]  inExp,
  input  logic [MANT_W-1:0] inMant,
  output logic              mantZero,
  output logic [WORD_W-1:0] outWord,
  output logic [PREC_W-1:0] outPrec,
  output logic              isSpecial,
  output logic              isErr
);

  // sigMask[i] = 1 when some mantissa bit below i is set
  logic [MANT_W-1:0] sigMask;

  for (genvar gi = 0; gi < MANT_W; gi++) begin : stage
    logic acc;
    if (gi == 0) begin : g_first
      assign acc = 1'b0;
    end else begin : g_rest
      assign acc = stage[gi-1].acc | inMant[gi-1];
    end
    assign sigMask[gi] = acc;
  end

  assign mantZero = ~(sigMask[MANT_W-1] | inMant[MANT_W-1]);

  logic [PREC_W-1:0] sigCount;
  always_comb begin
    sigCount = '0;
    for (int i = 0; i < MANT_W; i++)
      sigCount = sigCount + PREC_W'(sigMask[i]);
  end

  logic [MANT_W-1:0] keepMask;
  logic [MANT_W-1:0] flagMask;
  always_comb begin
    for (int i = 0; i < MANT_W; i++) begin
      keepMask[i] = (i >= MANT_W - int'(strobes.encPrec));
      flagMask[i] = (i == MAX_PREC - int'(strobes.encPrec));
    end
  end

  logic [MANT_W-1:0] nextMant;
  logic [PREC_W-1:0] nextPrec;
  always_comb begin
    nextMant = inMant;
    nextPrec = '0;
    if (strobes.special) begin
      nextMant = inMant;
    end else if (strobes.err) begin
      nextMant = '0;
    end else if (strobes.doEncode) begin
      nextMant = (inMant & keepMask) | flagMask;
      nextPrec = strobes.encPrec;
    end else if (strobes.doFlag) begin
      nextMant = inMant | MANT_W'(1);
      nextPrec = PREC_W'(MAX_PREC);
    end else if (strobes.doDecode) begin
      nextMant = inMant & sigMask;
      nextPrec = sigCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord   <= '0;
      outPrec   <= '0;
      isSpecial <= 1'b0;
      isErr     <= 1'b0;
    end else begin
      outWord   <= {inSign, inExp, nextMant};
      outPrec   <= nextPrec;
      isSpecial <= strobes.special;
      isErr     <= strobes.err;
    end
  end

endmodule

// File: rtl/anr_convert.sv
module anr_convert
  import anr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               mode,
  input  logic signed [PREQ_W-1:0] precReq,
  input  logic                     inSign,
  input  logic [EXP_W-1:0]         inExp,
  input  logic [MANT_W-1:0]        inMant,
  output logic [WORD_W-1:0]        outWord,
  output logic [PREC_W-1:0]        outPrec,
  output logic                     isSpecial,
  output logic                     isErr
);

  strobe_t strobes;
  logic    mantZero;

  anr_ctrl u_ctrl (
    .mode     (mode),
    .precReq  (precReq),
    .inExp    (inExp),
    .mantZero (mantZero),
    .strobes  (strobes)
  );

  anr_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inSign    (inSign),
    .inExp     (inExp),
    .inMant    (inMant),
    .mantZero  (mantZero),
    .outWord   (outWord),
    .outPrec   (outPrec),
    .isSpecial (isSpecial),
    .isErr     (isErr)
  );

endmodule

// File: rtl/anr_convert_checker.sv
module anr_convert_checker
  import anr_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [1:0]               mode,
  input logic signed [PREQ_W-1:0] precReq,
  input logic                     inSign,
  input logic [EXP_W-1:0]         inExp,
  input logic [MANT_W-1:0]        inMant,
  input logic [WORD_W-1:0]        outWord,
  input logic [PREC_W-1:0]        outPrec,
  input logic                     isSpecial,
  input logic                     isErr
);

  logic validQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= 1'b1;
  end

  logic specIn;
  assign specIn = (&inExp) || (inExp == '0 && inMant == '0);

  logic [MANT_W-1:0] outMant;
  logic [MANT_W-1:0] flagBit;
  assign outMant = outWord[MANT_W-1:0];
  always_comb begin
    if (int'(outPrec) <= MAX_PREC) flagBit = MANT_W'(1) << (MAX_PREC - int'(outPrec));
    else                           flagBit = '0;
  end

  assert_special_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    validQ && $past(specIn) |->
      outWord == $past({inSign, inExp, inMant}) && isSpecial && !isErr && outPrec == '0);

  assert_err_shape_R5: assert property (@(posedge clk) disable iff (!rstN)
    isErr |-> outMant == '0 && outPrec == '0 && !isSpecial);

  assert_enc_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    validQ && $past(mode == 2'd0 && !specIn && precReq > 0) |->
      (outMant & flagBit) != '0 && (outMant & (flagBit - MANT_W'(1))) == '0);

  assert_enc_clamp_R4: assert property (@(posedge clk) disable iff (!rstN)
    validQ && $past(mode == 2'd0 && !specIn && precReq > 22) |-> outPrec == PREC_W'(MAX_PREC));

  assert_dec_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    validQ && $past(mode[0] && !specIn && inMant == '0) |-> isErr);

  assert_mark_lsb_R8: assert property (@(posedge clk) disable iff (!rstN)
    validQ && $past(mode == 2'd2 && !specIn) |-> outWord[0] && outPrec == PREC_W'(MAX_PREC));

  assert_keep_head_R10: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> outWord[WORD_W-1:MANT_W] == $past({inSign, inExp}));

endmodule

bind anr_convert anr_convert_checker chk (
  .clk       (clk),
  .rstN      (rstN),
  .mode      (mode),
  .precReq   (precReq),
  .inSign    (inSign),
  .inExp     (inExp),
  .inMant    (inMant),
  .outWord   (outWord),
  .outPrec   (outPrec),
  .isSpecial (isSpecial),
  .isErr     (isErr)
);

// File: tb/anr_convert_test.sv
module anr_convert_test;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        mode = 2'd0;
  logic signed [5:0] precReq = '0;
  logic              inSign = 1'b0;
  logic [7:0]        inExp = '0;
  logic [22:0]       inMant = '0;
  logic [31:0]       outWord;
  logic [4:0]        outPrec;
  logic              isSpecial;
  logic              isErr;

  int vecCount = 0;
  int missCount = 0;

  always #5ns clk = ~clk;

  anr_convert uut (
    .clk(clk), .rstN(rstN), .mode(mode), .precReq(precReq),
    .inSign(inSign), .inExp(inExp), .inMant(inMant),
    .outWord(outWord), .outPrec(outPrec), .isSpecial(isSpecial), .isErr(isErr)
  );

  function automatic logic [22:0] pat(input int k);
    logic [31:0] h;
    h = 32'(k + 1) * 32'h9E3779B1;
    return h[30:8];
  endfunction

  // reference model written from the requirements
  task automatic model(input logic [1:0] md, input int req, input logic s,
                       input logic [7:0] e, input logic [22:0] m,
                       output logic [31:0] w, output int p,
                       output logic sp, output logic er);
    logic [22:0] t;
    int pc;
    int c;
    sp = (e == 8'hFF) || (e == 8'h00 && m == '0);
    er = 1'b0;
    p  = 0;
    w  = {s, e, m};
    if (!sp) begin
      if (md == 2'd0) begin
        if (req <= 0) begin
          er = 1'b1; w = {s, e, 23'd0};
        end else begin
          pc = (req > 22) ? 22 : req;
          t = m >> (23 - pc);
          t = t << (23 - pc);
          t = t | (23'd1 << (22 - pc));
          w = {s, e, t};
          p = pc;
        end
      end else if (md == 2'd2) begin
        w = {s, e, m | 23'd1};
        p = 22;
      end else begin
        if (m == '0) begin
          er = 1'b1; w = {s, e, 23'd0};
        end else begin
          c = 0;
          while (!m[c]) c++;
          t = m;
          t[c] = 1'b0;
          w = {s, e, t};
          p = 22 - c;
        end
      end
    end
  endtask

  task automatic apply(input string tag, input logic [1:0] md, input int req,
                       input logic s, input logic [7:0] e, input logic [22:0] m);
    logic [31:0] ew;
    int ep;
    logic es, ee;
    mode = md; precReq = 6'(req); inSign = s; inExp = e; inMant = m;
    model(md, req, s, e, m, ew, ep, es, ee);
    @(posedge clk); #2ns;
    vecCount++;
    if (outWord !== ew || int'(outPrec) != ep || isSpecial !== es || isErr !== ee) begin
      missCount++;
      $display("FAIL %s: word=%h prec=%0d sp=%b err=%b, expected word=%h prec=%0d sp=%b err=%b",
               tag, outWord, outPrec, isSpecial, isErr, ew, ep, es, ee);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2ns;
    vecCount++;
    if (outWord !== '0 || outPrec !== '0 || isSpecial !== 1'b0 || isErr !== 1'b0) begin
      missCount++;
      $display("FAIL R1: word=%h prec=%0d sp=%b err=%b, expected all zero",
               outWord, outPrec, isSpecial, isErr);
    end
    rstN = 1'b1;
    #1ns;
    vecCount++;
    if (outWord !== '0 || isErr !== 1'b0) begin
      missCount++;
      $display("FAIL R1: after release word=%h err=%b, expected 0 0", outWord, isErr);
    end

    // R3 R4 R5: encode over every precision request and many mantissas
    for (int r = -4; r <= 31; r++) begin
      for (int k = 0; k < 12; k++) begin
        logic [7:0] ex;
        ex = (k % 3 == 0) ? 8'h00 : 8'(8'h7F + k);
        if (ex == 8'h00 && pat(k) == '0) ex = 8'h01;
        if (r <= 0)       apply("R5", 2'd0, r, k[0], ex, pat(k));
        else if (r > 22)  apply("R4", 2'd0, r, k[0], ex, pat(k));
        else              apply("R3", 2'd0, r, k[0], ex, pat(k));
      end
      apply("R3", 2'd0, r, 1'b0, 8'h80, 23'h7FFFFF);
    end
    apply("R5", 2'd0, -32, 1'b1, 8'h10, 23'h123456);

    // R6 R9: decode with the marker at every position
    for (int c = 0; c < 23; c++) begin
      for (int k = 0; k < 6; k++) begin
        logic [22:0] m;
        m = ((pat(k) << (c + 1)) | (23'd1 << c));
        apply("R6", 2'd1, 0, k[1], 8'(8'h40 + k), m);
        apply("R9", 2'd3, 0, k[0], 8'(8'h01 + k), m);
      end
    end

    // R7: all-zero mantissa on a finite nonzero value
    for (int e = 1; e < 255; e += 11) begin
      apply("R7", 2'd1, 5, e[0], 8'(e), 23'd0);
      apply("R7", 2'd3, 5, e[1], 8'(e), 23'd0);
    end

    // R8: mark full precision
    for (int k = 0; k < 24; k++) begin
      apply("R8", 2'd2, k - 8, k[0], 8'(k + 1), pat(k));
    end
    apply("R8", 2'd2, 0, 1'b0, 8'h00, 23'd2);

    // R2: specials in every mode
    for (int md = 0; md < 4; md++) begin
      for (int r = -2; r <= 30; r += 8) begin
        apply("R2", 2'(md), r, 1'b0, 8'h00, 23'd0);
        apply("R2", 2'(md), r, 1'b1, 8'h00, 23'd0);
        apply("R2", 2'(md), r, 1'b0, 8'hFF, 23'd0);
        apply("R2", 2'(md), r, 1'b1, 8'hFF, 23'd0);
        apply("R2", 2'(md), r, 1'b0, 8'hFF, 23'h400000);
        apply("R2", 2'(md), r, 1'b1, 8'hFF, pat(r + 9) | 23'd1);
      end
    end

    // R10 R11: sign and exponent carried, one-cycle latency on back-to-back inputs
    for (int e = 0; e < 256; e += 3) begin
      mode = 2'(e); precReq = 6'(e % 29); inSign = e[2]; inExp = 8'(e); inMant = pat(e);
      @(posedge clk); #2ns;
      vecCount++;
      if (outWord[31:23] !== {e[2], 8'(e)}) begin
        missCount++;
        $display("FAIL R10: head=%h, expected %h", outWord[31:23], {e[2], 8'(e)});
      end
    end
    apply("R11", 2'd2, 0, 1'b1, 8'h33, 23'h000010);
    apply("R11", 2'd1, 0, 1'b0, 8'h34, 23'h000010);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule